// File: doc/BRIEF.md
# Ternary-Weight Broadcast Matrix Accumulator

This block forms matrix products in which every weight is -1, 0 or +1 and every activation is a small signed integer. A single 16-bit input word arrives per cycle: the upper byte holds five ternary weights packed in base 3, and the lower byte holds one signed 8-bit activation. The packed byte is unpacked with no lookup table into a per-column zero mask and a per-column sign mask. Those five weights go to every cell of a grid with `SLICES` rows and five columns. Each cell holds the activation of its row and, on each accepted weight cycle, adds it, subtracts it or leaves its accumulator alone. No multiplier is used. Adding rows (slices) raises the operations per clock without widening the input word.

A tile opens with a start strobe, which clears all accumulators. After `tile_len` accepted weight cycles, the block copies the accumulator values into an output chain. The chain emits one result per clock with a valid flag while the next tile is already accumulating. Activations are shifted into the rows by a load strobe and stay in place until they are loaded again. Accumulators saturate rather than wrap.

Top module: `tern_mm`

## Requirements
- R1: Weight byte b (0..242) is read as five base-3 digits, with the least significant digit driving column 0. Digit 0 gives weight 0, digit 1 gives +1 and digit 2 gives -1. So byte 0 gives all zeros, byte 1 gives +1 in column 0 and byte 2 gives -1 in column 0.
- R2: Weight bytes 243 to 255 decode to five zero weights and leave every accumulator unchanged.
- R3: On an accepted weight cycle, the cell in row s, column c adds w_c times the activation of row s. A zero weight leaves that cell unchanged.
- R4: While act_load is high, in_bus[7:0] enters row 0 and every row s>0 takes the previous value of row s-1. A weight in the same cycle uses the activations held before that clock edge.
- R5: Accumulators are 16-bit signed and saturate at +32767 and -32768 on every addition, instead of wrapping.
- R6: tile_start clears every accumulator and opens a tile. A weight presented in the same cycle becomes the first term of the new tile. A start in the middle of a tile discards the partial sums.
- R7: A tile ends on the accepted weight cycle that brings its count to tile_len (tile_len of 0 never ends a tile). Weights offered while no tile is open, including those after an end and before the next start, are ignored.
- R8: After a tile ends, res_valid is high for exactly SLICES*5 consecutive cycles, starting the cycle after the final weight's edge. Results come out in the order s*5+c (row-major, column 0 first). res_valid is low at all other times.
- R9: A new tile accumulates while the previous results drain. If the new tile ends during the drain, output restarts with the new results.
- R10: Reset clears accumulators, activations and res_valid. A tile run after reset with no activation load yields all-zero results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_start | input | 1 | Clears the accumulators and opens a tile |
| w_valid | input | 1 | in_bus[15:8] carries a packed weight byte |
| act_load | input | 1 | in_bus[7:0] shifts into the activation rows |
| in_bus | input | 16 | {packed weight byte, signed activation byte} |
| tile_len | input | LEN_W (10) | Weight cycles per tile |
| res_valid | output | 1 | res_data holds a result |
| res_data | output | 16 | Signed result, one per cycle |

## Verification
An accepted weight alters the accumulators at the next clock edge. The first result of a tile appears on the output the cycle after the edge that accepts the tile's final weight, and each further result follows one cycle later. An activation load changes the operand used by weights starting with the next cycle. The bench model advances on the same rising edge as the design, using only the inputs, and compares res_valid and res_data in the middle of every cycle. Each comparison therefore lands exactly where these latencies place the result.

// File: rtl/tern_mm_pkg.sv
package tern_mm_pkg;

    localparam int TRITS  = 5;
    localparam int WB_W   = 8;
    localparam int ACT_W  = 8;
    localparam int ACC_W  = 16;
    localparam int unsigned PACK_LIMIT = 3 ** TRITS;

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // zero: weight is 0 in that column; neg: weight is -1 in that column
    typedef struct packed {
        logic [TRITS-1:0] zero;
        logic [TRITS-1:0] neg;
    } wdec_t;

    function automatic wdec_t unpack_trits(input logic [WB_W-1:0] b);
        wdec_t r;
        int unsigned v;
        r.zero = '1;
        r.neg  = '0;
        v = 32'(b);
        if (v < PACK_LIMIT) begin
            for (int p = 0; p < TRITS; p++) begin
                case (v % 3)
                    1: r.zero[p] = 1'b0;
                    2: begin
                        r.zero[p] = 1'b0;
                        r.neg[p]  = 1'b1;
                    end
                    default: ;
                endcase
                v = v / 3;
            end
        end
        return r;
    endfunction

    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] a,
        input logic signed [ACT_W:0]   d
    );
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {{(ACC_W-ACT_W){d[ACT_W]}}, d};
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? ACC_MIN : ACC_MAX;
        return s[ACC_W-1:0];
    endfunction

endpackage

// File: rtl/tern_mm_decode.sv
module tern_mm_decode
    import tern_mm_pkg::*;
(
    input  logic [WB_W-1:0] wbyte,
    output wdec_t           dec
);
    always_comb dec = unpack_trits(wbyte);
endmodule

// File: rtl/tern_mm_cell.sv
module tern_mm_cell
    import tern_mm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    zero,
    input  logic                    neg,
    input  logic signed [ACT_W-1:0] act,
    output logic signed [ACC_W-1:0] acc_nxt
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] base;
    logic signed [ACT_W:0]   term;

    always_comb begin
        base = clr ? '0 : acc_q;
        term = neg ? -{act[ACT_W-1], act} : {act[ACT_W-1], act};
        acc_nxt = (en && !zero) ? sat_add(base, term) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_nxt;
    end

    assert_zero_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (en && zero && !clr) |=> acc_q == $past(acc_q));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && !en) |=> acc_q == '0);

    assert_no_wrap_up_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !zero && !clr && (neg == act[ACT_W-1])) |=> acc_q >= $past(acc_q));

    assert_no_wrap_down_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !zero && !clr && (neg != act[ACT_W-1])) |=> acc_q <= $past(acc_q));
endmodule

// File: rtl/tern_mm_drain.sv
module tern_mm_drain
    import tern_mm_pkg::*;
#(
    parameter int N = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] din [N],
    output logic                    valid,
    output logic signed [ACC_W-1:0] data
);
    localparam int CNT_W = $clog2(N + 1);

    logic signed [ACC_W-1:0] sreg [N];
    logic [CNT_W-1:0]        rem;

    always_ff @(posedge clk) begin
        if (rst)             rem <= '0;
        else if (load)       rem <= CNT_W'(N);
        else if (rem != '0)  rem <= rem - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            sreg <= din;
        end else if (rem != '0) begin
            for (int i = 0; i < N - 1; i++) sreg[i] <= sreg[i+1];
            sreg[N-1] <= '0;
        end
    end

    assign valid = (rem != '0);
    assign data  = sreg[0];

    assert_drain_start_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (valid && rem == CNT_W'(N)));

    assert_drain_shift_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !load) |=> data == $past(sreg[1]));
endmodule

// File: rtl/tern_mm.sv
module tern_mm
    import tern_mm_pkg::*;
#(
    parameter int SLICES = 4,
    parameter int LEN_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tile_start,
    input  logic                    w_valid,
    input  logic                    act_load,
    input  logic [15:0]             in_bus,
    input  logic [LEN_W-1:0]        tile_len,
    output logic                    res_valid,
    output logic signed [ACC_W-1:0] res_data
);
    localparam int NRES = SLICES * TRITS;

    logic [WB_W-1:0]         wbyte;
    logic signed [ACT_W-1:0] abyte;
    logic signed [ACT_W-1:0] act_q [SLICES];
    wdec_t                   dec;

    logic                    active_q;
    logic [LEN_W-1:0]        cnt_q, cnt_base, cnt_nxt;
    logic                    accept, finish;
    logic signed [ACC_W-1:0] cell_nxt [NRES];

    assign wbyte = in_bus[15:8];
    assign abyte = in_bus[7:0];

    // stationary activation rows, loaded as a shift chain
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLICES; s++) act_q[s] <= '0;
        end else if (act_load) begin
            act_q[0] <= abyte;
            for (int s = 1; s < SLICES; s++) act_q[s] <= act_q[s-1];
        end
    end

    // tile sequencing
    always_comb begin
        accept   = w_valid && (active_q || tile_start);
        cnt_base = tile_start ? '0 : cnt_q;
        cnt_nxt  = cnt_base + LEN_W'(accept);
        finish   = accept && (cnt_nxt == tile_len) && (tile_len != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (finish)          active_q <= 1'b0;
            else if (tile_start) active_q <= 1'b1;
        end
    end

    tern_mm_decode u_decode (
        .wbyte (wbyte),
        .dec   (dec)
    );

    for (genvar s = 0; s < SLICES; s++) begin : g_row
        for (genvar c = 0; c < TRITS; c++) begin : g_col
            tern_mm_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .clr     (tile_start),
                .en      (accept),
                .zero    (dec.zero[c]),
                .neg     (dec.neg[c]),
                .act     (act_q[s]),
                .acc_nxt (cell_nxt[s*TRITS + c])
            );
        end
    end

    tern_mm_drain #(.N(NRES)) u_drain (
        .clk   (clk),
        .rst   (rst),
        .load  (finish),
        .din   (cell_nxt),
        .valid (res_valid),
        .data  (res_data)
    );

    assert_sign_only_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        (dec.neg & dec.zero) == '0);

    assert_ignore_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !tile_start) |=> $stable(cnt_q));

    assert_start_arms_R6: assert property (@(posedge clk) disable iff (rst)
        (tile_start && !finish) |=> active_q);
endmodule

// File: tb/tern_mm_bench.sv
`timescale 1ns/1ps
module tern_mm_bench;
    localparam int SLICES = 4;
    localparam int NRES   = SLICES * 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tile_start = 1'b0, w_valid = 1'b0, act_load = 1'b0;
    logic [15:0] in_bus = '0;
    logic [9:0]  tile_len = '0;
    logic        res_valid;
    logic signed [15:0] res_data;

    int    n_checks = 0, n_errors = 0;
    bit    done = 1'b0;
    string tag = "R10";

    // behavioural reference state
    int m_acc [NRES];
    int m_nacc [NRES];
    int m_act [SLICES];
    int m_w [5];
    bit m_active;
    int m_cnt;
    int m_q [$];

    always #2 clk = ~clk;

    tern_mm u_tern_mm (
        .clk (clk), .rst (rst), .tile_start (tile_start), .w_valid (w_valid),
        .act_load (act_load), .in_bus (in_bus), .tile_len (tile_len),
        .res_valid (res_valid), .res_data (res_data)
    );

    function automatic int clamp16(input int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NRES; i++) m_acc[i] = 0;
            for (int s = 0; s < SLICES; s++) m_act[s] = 0;
            m_active = 0; m_cnt = 0; m_q.delete();
        end else begin
            int v, d;
            bit acc_ok, fin;
            v = int'(in_bus[15:8]);
            for (int c = 0; c < 5; c++) m_w[c] = 0;
            if (v < 243) begin
                for (int c = 0; c < 5; c++) begin
                    d = v % 3;
                    m_w[c] = (d == 1) ? 1 : ((d == 2) ? -1 : 0);
                    v = v / 3;
                end
            end
            acc_ok = w_valid && (m_active || tile_start);
            if (tile_start) begin
                for (int i = 0; i < NRES; i++) m_nacc[i] = 0;
                m_cnt = 0;
            end else begin
                for (int i = 0; i < NRES; i++) m_nacc[i] = m_acc[i];
            end
            if (acc_ok) begin
                for (int s = 0; s < SLICES; s++)
                    for (int c = 0; c < 5; c++)
                        m_nacc[s*5+c] = clamp16(m_nacc[s*5+c] + m_w[c] * m_act[s]);
                m_cnt++;
            end
            fin = acc_ok && (m_cnt == int'(tile_len)) && (tile_len != 0);
            if (fin) m_active = 0;
            else if (tile_start) m_active = 1;
            if (fin) begin
                m_q.delete();
                for (int i = 0; i < NRES; i++) m_q.push_back(m_nacc[i]);
            end else if (m_q.size() > 0) begin
                void'(m_q.pop_front());
            end
            for (int i = 0; i < NRES; i++) m_acc[i] = m_nacc[i];
            if (act_load) begin
                for (int s = SLICES - 1; s > 0; s--) m_act[s] = m_act[s-1];
                m_act[0] = int'($signed(in_bus[7:0]));
            end
        end
    end

    // compare in the middle of every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ev;
            ev = (m_q.size() > 0);
            n_checks++;
            if (res_valid !== ev) begin
                n_errors++;
                $display("FAIL R8 (%s) res_valid actual %0b expected %0b", tag, res_valid, ev);
            end
            if (ev) begin
                n_checks++;
                if (int'(res_data) != m_q[0]) begin
                    n_errors++;
                    $display("FAIL %s res_data actual %0d expected %0d", tag, res_data, m_q[0]);
                end
            end
        end
    end

    task automatic step(input bit ts, input bit wv, input bit al,
                        input logic [7:0] wb, input logic [7:0] ab);
        tile_start = ts; w_valid = wv; act_load = al; in_bus = {wb, ab};
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'd0, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state seen at the port
        n_checks++;
        if (res_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R10 res_valid in reset actual %0b expected 0", res_valid);
        end
        rst = 1'b0;

        tag = "R10"; tile_len = 10'd3;
        step(1, 1, 0, 8'd121, 8'd0); step(0, 1, 0, 8'd242, 8'd0); step(0, 1, 0, 8'd1, 8'd0);
        idle(22);

        tag = "R4";
        step(0, 0, 1, 8'd0, 8'd5); step(0, 0, 1, 8'd0, 8'hFD);
        step(0, 0, 1, 8'd0, 8'd100); step(0, 0, 1, 8'd0, 8'h80);

        tag = "R1"; tile_len = 10'd6;
        step(1, 1, 0, 8'd1, 8'd0); step(0, 1, 0, 8'd2, 8'd0); step(0, 1, 0, 8'd242, 8'd0);
        step(0, 1, 0, 8'd121, 8'd0); step(0, 1, 0, 8'd80, 8'd0); step(0, 1, 0, 8'd13, 8'd0);
        idle(22);

        tag = "R3"; tile_len = 10'd4;
        step(1, 1, 0, 8'd0, 8'd0); step(0, 1, 0, 8'd9, 8'd0);
        step(0, 1, 0, 8'd0, 8'd0); step(0, 1, 0, 8'd18, 8'd0);
        idle(22);

        tag = "R2"; tile_len = 10'd5;
        step(1, 1, 0, 8'd243, 8'd0); step(0, 1, 0, 8'd250, 8'd0); step(0, 1, 0, 8'd255, 8'd0);
        step(0, 1, 0, 8'd3, 8'd0); step(0, 1, 0, 8'd254, 8'd0);
        idle(22);

        tag = "R4"; tile_len = 10'd3;
        step(1, 1, 1, 8'd121, 8'd7); step(0, 1, 1, 8'd242, 8'hF0); step(0, 1, 0, 8'd5, 8'd0);
        idle(22);

        tag = "R6"; tile_len = 10'd4;
        step(1, 1, 0, 8'd121, 8'd0); step(0, 1, 0, 8'd121, 8'd0);
        step(1, 1, 0, 8'd2, 8'd0); step(0, 1, 0, 8'd6, 8'd0);
        step(0, 1, 0, 8'd7, 8'd0); step(0, 1, 0, 8'd8, 8'd0);
        idle(22);
        step(1, 0, 0, 8'd0, 8'd0); step(0, 1, 0, 8'd40, 8'd0); step(0, 0, 0, 8'd0, 8'd0);
        step(0, 1, 0, 8'd41, 8'd0); step(0, 1, 0, 8'd42, 8'd0); step(0, 1, 0, 8'd43, 8'd0);
        idle(22);

        tag = "R7"; tile_len = 10'd2;
        step(0, 1, 0, 8'd121, 8'd0);
        step(1, 1, 0, 8'd121, 8'd0); step(0, 0, 0, 8'd0, 8'd0); step(0, 1, 0, 8'd242, 8'd0);
        step(0, 1, 0, 8'd121, 8'd0); step(0, 1, 0, 8'd121, 8'd0); step(0, 1, 0, 8'd121, 8'd0);
        idle(22);
        step(1, 1, 0, 8'd4, 8'd0); step(0, 1, 0, 8'd4, 8'd0);
        idle(22);

        tag = "R9"; tile_len = 10'd5;
        step(1, 1, 0, 8'd1, 8'd0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 8'(10 + i), 8'd0);
        step(1, 1, 0, 8'd200, 8'd0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 8'(100 + i), 8'd0);
        idle(25);

        tag = "R5"; tile_len = 10'd300;
        for (int i = 0; i < SLICES; i++) step(0, 0, 1, 8'd0, 8'h80);
        step(1, 1, 0, 8'd242, 8'd0);
        for (int i = 0; i < 299; i++) step(0, 1, 0, 8'd242, 8'd0);
        idle(22);
        step(1, 1, 0, 8'd121, 8'd0);
        for (int i = 0; i < 299; i++) step(0, 1, 0, 8'd121, 8'd0);
        idle(22);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL R7 watchdog actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule